// File: doc/BRIEF.md
# Two-Level Masked Interrupt Aggregator

This block combines the interrupt status of several sources into one level-sensitive interrupt line for a processor. The sources are a parameterised number of submodule interrupt registers plus two fixed ones: a clock status error register and a handshake error register. Each source carries a vector of live cause bits. The block samples these bits into a read-only status register. Each status register has its own read/write mask. When a source has any status bit that is active and unmasked, it sets one bit of a summary (pointer) register.

The pointer register has its own read/write mask. Any pointer bit that is active and unmasked drives the interrupt output. Software cannot clear a status bit or a pointer bit. A bit drops only when its cause goes away or when it is masked, and masking works at either level. After finding the interrupt, software reads the masked pointer to see which source to service. The raw pointer is readable at a separate address for diagnosis.

Top module: `intagg_top`

## Requirements
- R1: Each source's status register captures that source's cause vector on every clock. A read of group 0, index i returns it one clock later. Index order is: submodules 0..N_SUB-1, then the clock error source (N_SUB), then the handshake error source (N_SUB+1). An address is {group[1:0], index[IDX_W-1:0]}. With the defaults IDX_W=3, so status i is at address i, source mask i is at 8+i, and the pointer registers are at 16, 17 and 18.
- R2: Status registers are read-only. A write to group 0 changes no status value and no interrupt.
- R3: Each source has a read/write mask in group 1 (index i). A mask bit of 1 means masked, and every mask resets to all ones.
- R4: Raw pointer bit i (group 2, index 1) is 1 exactly when source i has a status bit that is 1 while its mask bit is 0.
- R5: The masked pointer (group 2, index 0) equals the raw pointer ANDed with the inverse of the pointer mask.
- R6: The pointer mask (group 2, index 2) is read/write, has N_SUB+2 bits, resets to all ones, and reads back zero-extended.
- R7: Writes to the masked pointer or raw pointer addresses are ignored. The pointer mask and the interrupt are unchanged.
- R8: The interrupt output is a registered, active-high level. It is high in the clock after any masked pointer bit is 1, and it falls one clock after the last one clears.
- R9: Setting the mask for an active cause, at either the source level or the pointer level, removes the interrupt while the cause stays active.
- R10: During reset the interrupt output is low and no read data is valid. A read is answered with bus_rvalid_o high on the clock after bus_rd_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_irq_i | input | N_SUB*SW | Live cause bits of the submodules, source i in bits [i*SW +: SW] |
| clk_err_i | input | SW | Live clock status error cause bits |
| hs_err_i | input | SW | Live handshake error cause bits |
| bus_addr_i | input | IDX_W+2 | Register address {group, index} |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | SW | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | SW | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid, one clock after bus_rd_i |
| irq_o | output | 1 | Level interrupt to the processor |

## Verification
On every cycle, the assertions check three things:
- The status registers track the cause inputs with one clock of delay.
- The interrupt line follows the masked pointer one clock later, in both directions.
- A write aimed at either read-only pointer address never disturbs the pointer mask.

Only the bench scenarios can show the rest: the mask reset values, the exact raw-versus-masked pointer contents for chosen mask patterns, and that masking at each level withdraws a live interrupt while the cause persists. The bench also shows that writes to status addresses leave every readable value intact.

// File: rtl/intagg_pkg.sv
package intagg_pkg;

    typedef enum logic [1:0] {
        GRP_STATUS  = 2'd0,
        GRP_SRCMASK = 2'd1,
        GRP_PTR     = 2'd2,
        GRP_NONE    = 2'd3
    } grp_e;

    localparam int PTR_IDX_MASKED = 0;
    localparam int PTR_IDX_RAW    = 1;
    localparam int PTR_IDX_MASK   = 2;

    typedef struct packed {
        logic       wr;
        logic       rd;
        grp_e       grp;
        logic [7:0] idx;
    } req_t;

    function automatic logic idx_is(input req_t r, input grp_e g, input int i);
        return (r.grp == g) && (r.idx == 8'(i));
    endfunction

endpackage

// File: rtl/intagg_decode.sv
module intagg_decode
    import intagg_pkg::*;
#(
    parameter int NSRC  = 6,
    parameter int IDX_W = 3,
    parameter int AW    = IDX_W + 2
) (
    input  logic [AW-1:0]   addr_i,
    input  logic            wr_i,
    input  logic            rd_i,
    output req_t            req_o,
    output logic [NSRC-1:0] src_mask_we_o,
    output logic            ptr_mask_we_o
);

    always_comb begin
        req_o.wr  = wr_i;
        req_o.rd  = rd_i;
        req_o.grp = grp_e'(addr_i[AW-1:AW-2]);
        req_o.idx = 8'(addr_i[IDX_W-1:0]);
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_we
        assign src_mask_we_o[g] = req_o.wr && idx_is(req_o, GRP_SRCMASK, g);
    end

    assign ptr_mask_we_o = req_o.wr && idx_is(req_o, GRP_PTR, PTR_IDX_MASK);

endmodule

// File: rtl/intagg_src_stage.sv
module intagg_src_stage #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] cause_i,
    input  logic          mask_we_i,
    input  logic [SW-1:0] wdata_i,
    output logic [SW-1:0] status_o,
    output logic [SW-1:0] mask_o,
    output logic          pend_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_o <= '0;
            mask_o   <= '1;
        end else begin
            status_o <= cause_i;
            if (mask_we_i) mask_o <= wdata_i;
        end
    end

    assign pend_o = |(status_o & ~mask_o);

endmodule

// File: rtl/intagg_ptr_stage.sv
module intagg_ptr_stage #(
    parameter int PW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] pend_i,
    input  logic          mask_we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [PW-1:0] ptr_raw_o,
    output logic [PW-1:0] ptr_masked_o,
    output logic [PW-1:0] ptr_mask_o,
    output logic          irq_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_mask_o <= '1;
            irq_o      <= 1'b0;
        end else begin
            if (mask_we_i) ptr_mask_o <= wdata_i[PW-1:0];
            irq_o <= |ptr_masked_o;
        end
    end

    assign ptr_raw_o    = pend_i;
    assign ptr_masked_o = pend_i & ~ptr_mask_o;

endmodule

// File: rtl/intagg_top.sv
module intagg_top
    import intagg_pkg::*;
#(
    parameter int N_SUB = 4,
    parameter int SW    = 8,
    parameter int NSRC  = N_SUB + 2,
    parameter int IDX_W = $clog2(NSRC),
    parameter int AW    = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SUB*SW-1:0] sub_irq_i,
    input  logic [SW-1:0]     clk_err_i,
    input  logic [SW-1:0]     hs_err_i,
    input  logic [AW-1:0]     bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [SW-1:0]     bus_wdata_i,
    input  logic              bus_rd_i,
    output logic [SW-1:0]     bus_rdata_o,
    output logic              bus_rvalid_o,
    output logic              irq_o
);

    localparam int PW = NSRC;

    req_t               req;
    logic [NSRC-1:0]    src_mask_we;
    logic               ptr_mask_we;
    logic [NSRC*SW-1:0] cause_all;
    logic [NSRC*SW-1:0] status_all;
    logic [SW-1:0]      status [NSRC];
    logic [SW-1:0]      smask  [NSRC];
    logic [PW-1:0]      pend;
    logic [PW-1:0]      ptr_raw;
    logic [PW-1:0]      ptr_masked;
    logic [PW-1:0]      ptr_mask;
    logic [SW-1:0]      rd_val;

    assign cause_all = {hs_err_i, clk_err_i, sub_irq_i};

    intagg_decode #(.NSRC(NSRC), .IDX_W(IDX_W), .AW(AW)) u_dec (
        .addr_i        (bus_addr_i),
        .wr_i          (bus_wr_i),
        .rd_i          (bus_rd_i),
        .req_o         (req),
        .src_mask_we_o (src_mask_we),
        .ptr_mask_we_o (ptr_mask_we)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        intagg_src_stage #(.SW(SW)) u_src (
            .clk       (clk),
            .rst       (rst),
            .cause_i   (cause_all[g*SW +: SW]),
            .mask_we_i (src_mask_we[g]),
            .wdata_i   (bus_wdata_i),
            .status_o  (status[g]),
            .mask_o    (smask[g]),
            .pend_o    (pend[g])
        );
        assign status_all[g*SW +: SW] = status[g];
    end

    intagg_ptr_stage #(.PW(PW), .DW(SW)) u_ptr (
        .clk          (clk),
        .rst          (rst),
        .pend_i       (pend),
        .mask_we_i    (ptr_mask_we),
        .wdata_i      (bus_wdata_i),
        .ptr_raw_o    (ptr_raw),
        .ptr_masked_o (ptr_masked),
        .ptr_mask_o   (ptr_mask),
        .irq_o        (irq_o)
    );

    always_comb begin
        rd_val = '0;
        case (req.grp)
            GRP_STATUS:  if (req.idx < 8'(NSRC)) rd_val = status[req.idx[IDX_W-1:0]];
            GRP_SRCMASK: if (req.idx < 8'(NSRC)) rd_val = smask[req.idx[IDX_W-1:0]];
            GRP_PTR: begin
                if (req.idx == 8'(PTR_IDX_MASKED))    rd_val = SW'(ptr_masked);
                else if (req.idx == 8'(PTR_IDX_RAW))  rd_val = SW'(ptr_raw);
                else if (req.idx == 8'(PTR_IDX_MASK)) rd_val = SW'(ptr_mask);
            end
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata_o  <= '0;
            bus_rvalid_o <= 1'b0;
        end else begin
            bus_rvalid_o <= req.rd;
            if (req.rd) bus_rdata_o <= rd_val;
        end
    end

endmodule

// File: rtl/intagg_top_chk.sv
module intagg_top_chk #(
    parameter int N_SUB = 4,
    parameter int SW    = 8,
    parameter int NSRC  = N_SUB + 2,
    parameter int IDX_W = $clog2(NSRC),
    parameter int AW    = IDX_W + 2
) (
    input logic               clk,
    input logic               rst,
    input logic               irq_o,
    input logic [NSRC-1:0]    ptr_masked,
    input logic [NSRC-1:0]    ptr_mask,
    input logic               bus_wr_i,
    input logic [AW-1:0]      bus_addr_i,
    input logic [NSRC*SW-1:0] cause_all,
    input logic [NSRC*SW-1:0] status_all
);

    localparam logic [AW-1:0] A_PMASKED = {2'd2, IDX_W'(0)};
    localparam logic [AW-1:0] A_PRAW    = {2'd2, IDX_W'(1)};

    a_r1_status_sampled: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status_all == $past(cause_all)));

    a_r8_irq_rises: assert property (@(posedge clk) disable iff (rst)
        (|ptr_masked) |=> irq_o);

    a_r8_irq_falls: assert property (@(posedge clk) disable iff (rst)
        !(|ptr_masked) |=> !irq_o);

    a_r7_ptr_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && (bus_addr_i == A_PMASKED || bus_addr_i == A_PRAW)) |=> $stable(ptr_mask));

endmodule

bind intagg_top intagg_top_chk #(.N_SUB(N_SUB), .SW(SW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_o      (irq_o),
    .ptr_masked (ptr_masked),
    .ptr_mask   (ptr_mask),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .cause_all  (cause_all),
    .status_all (status_all)
);

// File: tb/intagg_top_test.sv
module intagg_top_test;

    localparam int CLK_P = 10;
    localparam int N_SUB = 4;
    localparam int SW    = 8;
    localparam int NSRC  = N_SUB + 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_SUB*SW-1:0] sub_irq_i = '0;
    logic [SW-1:0]     clk_err_i = '0;
    logic [SW-1:0]     hs_err_i  = '0;
    logic [4:0]        bus_addr_i = '0;
    logic              bus_wr_i = 1'b0;
    logic [SW-1:0]     bus_wdata_i = '0;
    logic              bus_rd_i = 1'b0;
    logic [SW-1:0]     bus_rdata_o;
    logic              bus_rvalid_o;
    logic              irq_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    logic [SW-1:0] m_cause [NSRC];
    logic [SW-1:0] m_smask [NSRC];
    logic [NSRC-1:0] m_pmask;

    logic [SW-1:0] q_exp [$];
    string         q_tag [$];

    intagg_top #(.N_SUB(N_SUB), .SW(SW)) uut (
        .clk(clk), .rst(rst), .sub_irq_i(sub_irq_i), .clk_err_i(clk_err_i),
        .hs_err_i(hs_err_i), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rd_i(bus_rd_i), .bus_rdata_o(bus_rdata_o),
        .bus_rvalid_o(bus_rvalid_o), .irq_o(irq_o)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [NSRC-1:0] exp_raw();
        logic [NSRC-1:0] r = '0;
        for (int i = 0; i < NSRC; i++) r[i] = |(m_cause[i] & ~m_smask[i]);
        return r;
    endfunction

    function automatic logic exp_irq();
        return |(exp_raw() & ~m_pmask);
    endfunction

    task automatic drive_causes();
        for (int i = 0; i < N_SUB; i++) sub_irq_i[i*SW +: SW] = m_cause[i];
        clk_err_i = m_cause[N_SUB];
        hs_err_i  = m_cause[N_SUB+1];
    endtask

    task automatic set_cause(input int i, input logic [SW-1:0] v);
        @(negedge clk);
        m_cause[i] = v;
        drive_causes();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [SW-1:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
        @(negedge clk);
        bus_wr_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [4:0] a, input logic [SW-1:0] e, input string tag);
        @(negedge clk);
        bus_addr_i = a; bus_rd_i = 1'b1;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
        bus_rd_i = 1'b0;
    endtask

    task automatic check_irq(input string tag);
        @(negedge clk);
        compared++;
        if (irq_o !== exp_irq()) begin
            mismatched++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq_o, exp_irq());
        end
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < NSRC; i++) begin
            bus_read(5'(i), m_cause[i], {tag, " R1 status"});
            bus_read(5'(8 + i), m_smask[i], {tag, " R3 srcmask"});
        end
        bus_read(5'd17, SW'(exp_raw()), {tag, " R4 raw"});
        bus_read(5'd16, SW'(exp_raw() & ~m_pmask), {tag, " R5 masked"});
        bus_read(5'd18, SW'(m_pmask), {tag, " R6 ptrmask"});
        check_irq({tag, " R8"});
    endtask

    // monitor: pops expected read data when the design answers
    always @(posedge clk) begin
        #(CLK_P/4);
        if (bus_rvalid_o) begin
            compared++;
            if (q_exp.size() == 0) begin
                mismatched++;
                $display("FAIL R10 unexpected rvalid actual=%h expected=none", bus_rdata_o);
            end else begin
                logic [SW-1:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if (bus_rdata_o !== e) begin
                    mismatched++;
                    $display("FAIL %s actual=%h expected=%h", t, bus_rdata_o, e);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NSRC; i++) begin m_cause[i] = '0; m_smask[i] = '1; end
        m_pmask = '1;
        repeat (3) @(negedge clk);
        compared++;
        if (irq_o !== 1'b0 || bus_rvalid_o !== 1'b0) begin
            mismatched++;
            $display("FAIL R10 reset irq/rvalid actual=%b%b expected=00", irq_o, bus_rvalid_o);
        end
        rst = 1'b0;
        read_all("reset");

        // cause present but fully masked at source level
        set_cause(2, 8'h11);
        read_all("masked cause");

        // R2: write to a status address leaves it unchanged
        bus_write(5'd2, 8'hAA);
        read_all("R2 status write");

        // unmask at source level only
        m_smask[2] = 8'hFE; bus_write(5'd10, 8'hFE);
        read_all("src unmask");

        // unmask pointer bit 2 -> interrupt
        m_pmask = 6'h3B; bus_write(5'd18, 8'h3B);
        read_all("R8 ptr unmask");

        // R7: writes to pointer read-only addresses ignored
        bus_write(5'd16, 8'h00);
        bus_write(5'd17, 8'hFF);
        read_all("R7 ptr write");

        // R9: source-level mask withdraws interrupt
        m_smask[2] = 8'hFF; bus_write(5'd10, 8'hFF);
        read_all("R9 src mask");

        // re-unmask, then cause goes away -> R8 drop
        m_smask[2] = 8'h00; bus_write(5'd10, 8'h00);
        check_irq("R8 re-raise");
        set_cause(2, 8'h00);
        read_all("R8 cause gone");

        // clock error and handshake error sources
        set_cause(4, 8'h80);
        set_cause(5, 8'h01);
        m_smask[4] = 8'h7F; bus_write(5'd12, 8'h7F);
        m_smask[5] = 8'h00; bus_write(5'd13, 8'h00);
        m_pmask = 6'h00; bus_write(5'd18, 8'h00);
        read_all("R4 err sources");

        // R9: pointer-level masking one bit at a time
        m_pmask = 6'h10; bus_write(5'd18, 8'h10);
        read_all("R9 ptr mask one");
        m_pmask = 6'h30; bus_write(5'd18, 8'h30);
        read_all("R9 ptr mask both");

        // submodule 0 and 3 together with mixed masks
        set_cause(0, 8'h0F);
        set_cause(3, 8'hF0);
        m_smask[0] = 8'hF0; bus_write(5'd8, 8'hF0);
        m_smask[3] = 8'hF0; bus_write(5'd11, 8'hF0);
        read_all("R5 multi source");

        repeat (4) @(negedge clk);
        compared++;
        if (q_exp.size() != 0) begin
            mismatched++;
            $display("FAIL R10 pending reads actual=%0d expected=0", q_exp.size());
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule